// File: doc/BRIEF.md
# Interrupt In-Service Priority Tracker

This block sits between a set of pending interrupt request lines and a processor core. It records which priority levels are being serviced and uses that record to decide whether a new request may be accepted. There are two levels, low and high, with one in-service bit for each. Each request line carries its own level select. A request is accepted only when its level is strictly above every level currently in service. When several requests qualify, the high level wins. Within a level, the lowest source index wins.

An accepted request produces a one-cycle acknowledge pulse. The pulse carries the source index, the source's service address and the level of the source. In the same clock edge the in-service bit for that level is set. The core signals the end of a service routine with an interrupt-return strobe. That strobe releases the highest level in service and raises a one-cycle request to pop two bytes from the stack. An ordinary subroutine return is also reported to the block, but it releases nothing. After an ordinary return, requests at the same level or a lower level therefore stay blocked. Upstream logic merges the many capture/compare event flags onto a few request lines before they reach this block.

Top module: `irq_prio_tracker`

## Requirements
- R1: After reset, `ack_o`, `pop2_o`, `act_bits_o` and `cur_lvl_o` are all 0.
- R2: A low-level request (`req_hi_i` bit = 0) that is sampled when no level is in service produces `ack_o` = 1 one cycle later. `ack_o` is 0 in every cycle where no request was accepted at the previous edge.
- R3: A high-level request (`req_hi_i` bit = 1) is accepted whenever the high in-service bit is clear, even if the low bit is set.
- R4: A request whose level is equal to or lower than a level in service is not acknowledged for as long as that level stays in service.
- R5: When requests qualify at both levels, the high level wins. Within one level, the lowest pending index wins. `ack_idx_o` carries the winning index and `ack_hi_o` carries its level.
- R6: While `ack_o` = 1, `ack_vec_o` = VEC_BASE + index × VEC_STRIDE, truncated to VEC_W bits. While `ack_o` = 0, `ack_idx_o`, `ack_vec_o` and `ack_hi_o` are 0.
- R7: The in-service bit of the accepted level is set at the same edge that raises `ack_o`. Bit 1 of `act_bits_o` is the high level and bit 0 is the low level.
- R8: An `irq_ret_i` pulse clears the high in-service bit if it is set, and otherwise clears the low bit. `pop2_o` is 1 exactly in the cycle after each sampled `irq_ret_i`.
- R9: `plain_ret_i` changes neither `act_bits_o` nor `pop2_o`.
- R10: When a return and a request are sampled in the same cycle, acceptance is decided on the in-service bits as they were before that return. The clear and the set are then applied together.
- R11: `cur_lvl_o` encodes the highest level in service: 0 = none, 1 = low, 2 = high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Pending request lines, one per source |
| req_hi_i | input | N_SRC | Level of each source: 1 = high, 0 = low |
| irq_ret_i | input | 1 | Interrupt-return strobe |
| plain_ret_i | input | 1 | Ordinary return strobe (releases nothing) |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_idx_o | output | IDX_W | Index of the acknowledged source |
| ack_vec_o | output | VEC_W | Service address of the acknowledged source |
| ack_hi_o | output | 1 | Level of the acknowledged source |
| act_bits_o | output | 2 | In-service bits: bit 1 = high, bit 0 = low |
| cur_lvl_o | output | 2 | Highest level in service, encoded |
| pop2_o | output | 1 | Two-byte stack pop request |

## Verification
The interplay that matters is a return arriving in the same cycle as a new request. Two directed cases provoke it. In the first, only the low level is in service, and a return arrives together with a high request. The bench expects the high request to be acknowledged and the bits to become high-only. In the second, only the high level is in service, and a return arrives together with a low request. The bench expects the low request to be refused in that cycle and acknowledged one cycle later. A random phase then mixes requests, returns and ordinary returns, and a behavioural model judges the outputs on every clock.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  // service address of a source
  function automatic int unsigned vec_calc(input int unsigned idx,
                                           input int unsigned base,
                                           input int unsigned stride);
    return base + idx * stride;
  endfunction

  // highest in-service level from the two bits {high, low}
  function automatic lvl_e lvl_of(input logic [1:0] bits);
    if (bits[1])      return LVL_HIGH;
    else if (bits[0]) return LVL_LOW;
    else              return LVL_NONE;
  endfunction

  // bits released by an interrupt return: top level only
  function automatic logic [1:0] ret_clear(input logic [1:0] bits);
    return bits[1] ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |mask;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_level_state.sv
module irq_level_state
  import irq_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_lo,
  input  logic       set_hi,
  input  logic       ret,
  output logic [1:0] bits
);
  logic [1:0] clr_mask;
  logic [1:0] set_mask;
  logic [1:0] bits_nx;

  always_comb begin
    clr_mask = ret ? ret_clear(bits) : 2'b00;
    set_mask = {set_hi, set_lo};
    bits_nx  = (bits & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits <= 2'b00;
    else        bits <= bits_nx;
  end

  a_r8_ret_drops_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && bits[1] && !set_hi) |=> !bits[1]);

  a_r8_ret_drops_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && bits == 2'b01 && !set_lo) |=> !bits[0]);

  a_r7_set_low_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    set_lo |-> (bits == 2'b00));
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
  import irq_trk_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] req_hi_i,
  input  logic             irq_ret_i,
  input  logic             plain_ret_i,
  output logic             ack_o,
  output logic [IDX_W-1:0] ack_idx_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic             ack_hi_o,
  output logic [1:0]       act_bits_o,
  output logic [1:0]       cur_lvl_o,
  output logic             pop2_o
);
  logic [N_SRC-1:0] hi_mask, lo_mask;
  logic             hi_any, lo_any;
  logic [IDX_W-1:0] hi_idx, lo_idx;
  logic             hi_ok, lo_ok, grant;
  logic [IDX_W-1:0] grant_idx;
  logic [1:0]       act_bits;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_split
      assign hi_mask[g] = req_i[g] &  req_hi_i[g];
      assign lo_mask[g] = req_i[g] & ~req_hi_i[g];
    end
  endgenerate

  irq_pick #(.N(N_SRC), .IW(IDX_W)) u_pick_hi (
    .mask(hi_mask), .any(hi_any), .idx(hi_idx));
  irq_pick #(.N(N_SRC), .IW(IDX_W)) u_pick_lo (
    .mask(lo_mask), .any(lo_any), .idx(lo_idx));

  // acceptance uses the bits held before any same-cycle return
  always_comb begin
    hi_ok     = hi_any && !act_bits[1];
    lo_ok     = !hi_ok && lo_any && (act_bits == 2'b00);
    grant     = hi_ok || lo_ok;
    grant_idx = hi_ok ? hi_idx : lo_idx;
  end

  irq_level_state u_state (
    .clk(clk), .rst_n(rst_n), .set_lo(lo_ok), .set_hi(hi_ok),
    .ret(irq_ret_i), .bits(act_bits));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_o     <= 1'b0;
      ack_idx_o <= '0;
      ack_vec_o <= '0;
      ack_hi_o  <= 1'b0;
      pop2_o    <= 1'b0;
    end else begin
      ack_o     <= grant;
      ack_idx_o <= grant ? grant_idx : '0;
      ack_vec_o <= grant ? VEC_W'(vec_calc(32'(grant_idx), VEC_BASE, VEC_STRIDE)) : '0;
      ack_hi_o  <= hi_ok;
      pop2_o    <= irq_ret_i;
    end
  end

  assign act_bits_o = act_bits;
  assign cur_lvl_o  = lvl_of(act_bits);

  a_r4_low_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_hi_o) |-> ($past(act_bits) == 2'b00));

  a_r3_high_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && ack_hi_o) |-> !$past(act_bits[1]));

  a_r7_level_marked: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (ack_hi_o ? act_bits[1] : act_bits[0]));

  a_r8_pop_after_ret: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ret_i |=> pop2_o);

  a_r9_plain_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_ret_i && !irq_ret_i && !grant) |=> $stable(act_bits));

  a_r11_lvl_high: assert property (@(posedge clk) disable iff (!rst_n)
    act_bits[1] |-> (cur_lvl_o == 2'd2));
endmodule

// File: tb/irq_prio_tracker_bench.sv
module irq_prio_tracker_bench;
  localparam int N = 8;
  localparam int BASE = 3;
  localparam int STRIDE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_i = '0, req_hi_i = '0;
  logic irq_ret_i = 1'b0, plain_ret_i = 1'b0;
  logic ack_o, ack_hi_o, pop2_o;
  logic [2:0] ack_idx_o;
  logic [15:0] ack_vec_o;
  logic [1:0] act_bits_o, cur_lvl_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_tracker u_irq_prio_tracker (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_hi_i(req_hi_i),
    .irq_ret_i(irq_ret_i), .plain_ret_i(plain_ret_i), .ack_o(ack_o),
    .ack_idx_o(ack_idx_o), .ack_vec_o(ack_vec_o), .ack_hi_o(ack_hi_o),
    .act_bits_o(act_bits_o), .cur_lvl_o(cur_lvl_o), .pop2_o(pop2_o));

  // behavioural reference model
  int m_hi = 0, m_lo = 0, m_ack = 0, m_idx = 0, m_ackhi = 0, m_pop = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_ack = 0; m_idx = 0; m_ackhi = 0; m_pop = 0;
    end else begin
      int win;
      int winhi;
      win = -1; winhi = 0;
      if (m_hi == 0) begin
        for (int k = 0; k < N; k++)
          if (win < 0 && req_i[k] && req_hi_i[k]) begin win = k; winhi = 1; end
      end
      if (win < 0 && m_hi == 0 && m_lo == 0) begin
        for (int k = 0; k < N; k++)
          if (win < 0 && req_i[k] && !req_hi_i[k]) win = k;
      end
      m_pop = irq_ret_i ? 1 : 0;
      if (irq_ret_i) begin
        if (m_hi != 0) m_hi = 0; else m_lo = 0;
      end
      m_ack = (win >= 0) ? 1 : 0;
      m_idx = (win >= 0) ? win : 0;
      m_ackhi = winhi;
      if (win >= 0) begin
        if (winhi != 0) m_hi = 1; else m_lo = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lvl;
      lvl = (m_hi != 0) ? 2 : (m_lo != 0) ? 1 : 0;
      chk("R2 ack", int'(ack_o), m_ack);
      chk("R5 idx", int'(ack_idx_o), m_idx);
      chk("R5 ack_hi", int'(ack_hi_o), m_ackhi);
      chk("R6 vec", int'(ack_vec_o), m_ack != 0 ? BASE + m_idx * STRIDE : 0);
      chk("R7 act_bits", int'(act_bits_o), m_hi * 2 + m_lo);
      chk("R8 pop", int'(pop2_o), m_pop);
      chk("R11 cur_lvl", int'(cur_lvl_o), lvl);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) step();
    chk("R1 reset ack", int'(ack_o), 0);
    chk("R1 reset act", int'(act_bits_o), 0);
    chk("R1 reset pop", int'(pop2_o), 0);
    chk("R1 reset lvl", int'(cur_lvl_o), 0);
    rst_n = 1'b1;
    step();
    // low request from idle
    req_i = 8'b0000_1000; step();
    chk("R2 low ack", int'(ack_o), 1);
    chk("R6 vec idx3", int'(ack_vec_o), 'h1B);
    chk("R7 low set", int'(act_bits_o), 1);
    step();
    chk("R4 same level blocked", int'(ack_o), 0);
    // high beats low, lowest high index wins, nesting over low
    req_i = 8'b0110_1010; req_hi_i = 8'b0110_0000; step();
    chk("R3 high nests", int'(ack_o), 1);
    chk("R5 lowest high idx", int'(ack_idx_o), 5);
    chk("R11 lvl high", int'(cur_lvl_o), 2);
    step();
    chk("R4 equal high blocked", int'(ack_o), 0);
    req_i = '0; step();
    plain_ret_i = 1'b1; step();
    plain_ret_i = 1'b0;
    chk("R9 plain keeps bits", int'(act_bits_o), 3);
    chk("R9 plain no pop", int'(pop2_o), 0);
    irq_ret_i = 1'b1; step();
    irq_ret_i = 1'b0;
    chk("R8 ret clears high", int'(act_bits_o), 1);
    chk("R8 pop", int'(pop2_o), 1);
    step();
    // same cycle: return of low plus high request
    irq_ret_i = 1'b1; req_i = 8'b0100_0000; step();
    irq_ret_i = 1'b0; req_i = '0;
    chk("R10 high ack on ret", int'(ack_idx_o), 6);
    chk("R10 bits hi only", int'(act_bits_o), 2);
    // same cycle: return of high plus low request
    irq_ret_i = 1'b1; req_i = 8'b0000_0100; step();
    irq_ret_i = 1'b0;
    chk("R10 low refused", int'(ack_o), 0);
    chk("R10 bits clear", int'(act_bits_o), 0);
    step();
    chk("R10 low ack next", int'(ack_idx_o), 2);
    req_i = '0;
    irq_ret_i = 1'b1; step();
    irq_ret_i = 1'b0;
    req_i = 8'b1000_0001; req_hi_i = 8'b1000_0000; step();
    chk("R5 high over low", int'(ack_idx_o), 7);
    req_i = '0; irq_ret_i = 1'b1; step();
    irq_ret_i = 1'b0;
    // random phase judged by the model
    for (int c = 0; c < 3000; c++) begin
      req_i       = $urandom & $urandom;
      req_hi_i    = $urandom;
      irq_ret_i   = ($urandom % 6) == 0;
      plain_ret_i = ($urandom % 6) == 0;
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    done = 1;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule